// File: doc/BRIEF.md
# Programming Interface Enable Controller

This block decides when the serial programming physical layer is switched on and when it is let go again. It runs on the chip's system clock and watches the programmer's clock and data lines through synchronizers. A programming session is requested either by pulling the reset-enable pin low or, when the reset function of that pin is configured off, by a digital flag that reports a high voltage on the pin. Once a session is requested, the block waits for a delay-complete input. It then counts rising edges of the programmer clock. It enables the physical layer only after sixteen consecutive edges at which the data line is sampled high.

While a session is being entered or is running, the block asks for the core to be held in reset. On entry it gives the physical layer a one-cycle pulse, which tells the layer to start in receive mode and wait for a start bit. A latched memory-enable bit, set and cleared by the access layer only during an active session, decides how the session ends. With the bit clear, dropping the request ends the session at once. With the bit set, the session survives a dropped request and only a power-on reset ends it.

All pins are plain control and status lines. No data streams through the block, so it has no valid/ready handshake.

Top module: `pie_enable_ctrl`

## Requirements
- R1: While por_n is low and in the first cycle after it rises, phy_active, phy_rx_init, core_rst_req and nvm_en are all 0.
- R2: The request comes from the reset-enable pin when rst_disabled is 0 (rst_pin_n low means requested), and from hv_present when rst_disabled is 1 (high means requested). The source that is not selected has no effect.
- R3: core_rst_req is 1 in every cycle in which the controller is waiting, counting or active. It is 0 when idle.
- R4: No programmer clock edge is counted until delay_done has been seen high while a request is present.
- R5: phy_active goes to 1 only after 16 programmer clock rising edges with pdata high, counted after the delay. After 15 such edges it is still 0.
- R6: A programmer clock rising edge with pdata low restarts the count at zero.
- R7: If the request drops before entry completes, the controller returns to idle and core_rst_req goes to 0. A new request starts counting from zero.
- R8: With nvm_en at 0, a dropped request clears phy_active and core_rst_req.
- R9: With nvm_en at 1, phy_active stays 1 even after the request drops. Only por_n low clears it.
- R10: phy_rx_init is a single-cycle pulse, given in the first cycle that phy_active is 1.
- R11: nvm_set and nvm_clr change nvm_en only while phy_active is 1, and nvm_clr wins when both are high. While inactive they are ignored.
- R12: The pin inputs rst_pin_n, hv_present, pclk and pdata pass through SYNC_STAGES (2) flip-flops before use. A change on a pin reaches the registered outputs three clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_n | input | 1 | Reset-enable pin level, low requests a session |
| hv_present | input | 1 | High-voltage-on-pin flag from analog detector |
| rst_disabled | input | 1 | Configuration: reset pin function turned off, use hv_present |
| delay_done | input | 1 | Reset delay elapsed (synchronous) |
| pclk | input | 1 | Programmer clock pin |
| pdata | input | 1 | Programmer data pin level |
| nvm_set | input | 1 | Access layer sets the memory-enable bit |
| nvm_clr | input | 1 | Access layer clears the memory-enable bit |
| phy_active | output | 1 | Physical layer enabled |
| phy_rx_init | output | 1 | One-cycle pulse: physical layer starts in receive mode |
| core_rst_req | output | 1 | Hold core in reset |
| nvm_en | output | 1 | Latched memory-enable status |

## Verification
The bench targets the count boundary: 15 high edges must leave the layer off and the 16th must turn it on. A low sample in the middle of a run must cost the whole count, so a design that only paused counting would enter early. A request dropped and raised again mid-count must start from zero, or a leftover count would enable the layer after too few edges. The bench also checks that the locked session survives a released pin, that memory-enable requests are ignored outside a session, and that the unselected request source is ignored. A wrong mux there would start a session from the wrong pin.

// File: rtl/pie_pkg.sv
package pie_pkg;
  typedef enum logic [1:0] {
    PIE_IDLE   = 2'd0,
    PIE_WAIT   = 2'd1,
    PIE_COUNT  = 2'd2,
    PIE_ACTIVE = 2'd3
  } pie_state_e;
endpackage

// File: rtl/pie_sync.sv
module pie_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pie_entry_cnt.sv
module pie_entry_cnt #(
  parameter int ENTRY_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic pclk_s,
  input  logic pdata_s,
  output logic done
);
  localparam int CW = $clog2(ENTRY_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          pclk_d;
  logic          rise;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) pclk_d <= 1'b0;
    else        pclk_d <= pclk_s;
  end

  assign rise = pclk_s & ~pclk_d;
  assign done = run & rise & pdata_s & (cnt == CW'(ENTRY_CYCLES - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              cnt <= '0;
    else if (!run || done)   cnt <= '0;
    else if (rise)           cnt <= pdata_s ? cnt + 1'b1 : '0;
  end
endmodule

// File: rtl/pie_ctrl_fsm.sv
module pie_ctrl_fsm
  import pie_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       req,
  input  logic       delay_done,
  input  logic       entry_done,
  input  logic       nvm_set,
  input  logic       nvm_clr,
  output pie_state_e state,
  output logic       phy_active,
  output logic       phy_rx_init,
  output logic       core_rst_req,
  output logic       nvm_en
);
  pie_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PIE_IDLE:   if (req) nxt = PIE_WAIT;
      PIE_WAIT:   if (!req) nxt = PIE_IDLE;
                  else if (delay_done) nxt = PIE_COUNT;
      PIE_COUNT:  if (!req) nxt = PIE_IDLE;
                  else if (entry_done) nxt = PIE_ACTIVE;
      PIE_ACTIVE: if (!req && !nvm_en) nxt = PIE_IDLE;
      default:    nxt = PIE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state       <= PIE_IDLE;
      phy_rx_init <= 1'b0;
      nvm_en      <= 1'b0;
    end else begin
      state       <= nxt;
      phy_rx_init <= (nxt == PIE_ACTIVE) && (state != PIE_ACTIVE);
      if (state == PIE_ACTIVE) begin
        if (nvm_clr)      nvm_en <= 1'b0;
        else if (nvm_set) nvm_en <= 1'b1;
      end
    end
  end

  assign phy_active   = (state == PIE_ACTIVE);
  assign core_rst_req = (state != PIE_IDLE);
endmodule

// File: rtl/pie_enable_ctrl.sv
module pie_enable_ctrl
  import pie_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic hv_present,
  input  logic rst_disabled,
  input  logic delay_done,
  input  logic pclk,
  input  logic pdata,
  input  logic nvm_set,
  input  logic nvm_clr,
  output logic phy_active,
  output logic phy_rx_init,
  output logic core_rst_req,
  output logic nvm_en
);
  localparam int NPIN = 4;
  localparam logic [NPIN-1:0] PIN_RST = 4'b0001;

  logic [NPIN-1:0] pins_raw;
  logic [NPIN-1:0] pins_s;
  logic            rst_n_s, hv_s, pclk_s, pdata_s;
  logic            req_s;
  logic            entry_done;
  pie_state_e      state;

  assign pins_raw = {pdata, pclk, hv_present, rst_pin_n};

  pie_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .por_n(por_n), .d(pins_raw), .q(pins_s)
  );

  assign rst_n_s = pins_s[0];
  assign hv_s    = pins_s[1];
  assign pclk_s  = pins_s[2];
  assign pdata_s = pins_s[3];

  generate
    if (SYNC_STAGES < 1) begin : g_bad
      initial $error("SYNC_STAGES must be at least 1");
    end
  endgenerate

  assign req_s = rst_disabled ? hv_s : ~rst_n_s;

  pie_entry_cnt #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_cnt (
    .clk(clk), .por_n(por_n), .run(state == PIE_COUNT),
    .pclk_s(pclk_s), .pdata_s(pdata_s), .done(entry_done)
  );

  pie_ctrl_fsm u_fsm (
    .clk(clk), .por_n(por_n), .req(req_s), .delay_done(delay_done),
    .entry_done(entry_done), .nvm_set(nvm_set), .nvm_clr(nvm_clr),
    .state(state), .phy_active(phy_active), .phy_rx_init(phy_rx_init),
    .core_rst_req(core_rst_req), .nvm_en(nvm_en)
  );
endmodule

// File: rtl/pie_enable_chk.sv
module pie_enable_chk (
  input logic clk,
  input logic por_n,
  input logic req_s,
  input logic phy_active,
  input logic phy_rx_init,
  input logic core_rst_req,
  input logic nvm_en
);
  AST_ACTIVE_HOLDS_RST: assert property (@(posedge clk) disable iff (!por_n)
    phy_active |-> core_rst_req); // R3
  AST_RX_ON_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(phy_active) |-> phy_rx_init); // R10
  AST_RX_ONLY_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
    phy_rx_init |-> (phy_active && !$past(phy_active))); // R10
  AST_LOCKED_STAYS: assert property (@(posedge clk) disable iff (!por_n)
    (phy_active && nvm_en) |=> phy_active); // R9
  AST_FAST_EXIT: assert property (@(posedge clk) disable iff (!por_n)
    (phy_active && !nvm_en && !req_s) |=> !phy_active); // R8
  AST_NVM_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    !phy_active |=> $stable(nvm_en)); // R11
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (!req_s && !phy_active) |=> !core_rst_req); // R7
endmodule

bind pie_enable_ctrl pie_enable_chk u_chk (
  .clk(clk), .por_n(por_n), .req_s(req_s), .phy_active(phy_active),
  .phy_rx_init(phy_rx_init), .core_rst_req(core_rst_req), .nvm_en(nvm_en)
);

// File: tb/pie_enable_ctrl_tb.sv
`timescale 1ns/1ps
module pie_enable_ctrl_tb;
  localparam int N_ENTRY = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_pin_n = 1'b1, hv_present = 1'b0, rst_disabled = 1'b0;
  logic delay_done = 1'b0, pclk = 1'b0, pdata = 1'b0, nvm_set = 1'b0, nvm_clr = 1'b0;
  logic phy_active, phy_rx_init, core_rst_req, nvm_en;

  int total = 0, bad = 0, rx_pulses = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pie_enable_ctrl u_dut (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .hv_present(hv_present),
    .rst_disabled(rst_disabled), .delay_done(delay_done), .pclk(pclk), .pdata(pdata),
    .nvm_set(nvm_set), .nvm_clr(nvm_clr), .phy_active(phy_active),
    .phy_rx_init(phy_rx_init), .core_rst_req(core_rst_req), .nvm_en(nvm_en)
  );

  function automatic void chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endfunction

  // behavioural reference: pins delayed two cycles, phases 0 idle 1 wait 2 count 3 active
  int ms, mc;
  bit mn, mrx;
  bit qp[$], qd[$], qr[$], qh[$];
  bit pclk_old;

  always @(posedge clk) begin
    bit req, rise, done;
    int nxt;
    if (!por_n) begin
      ms = 0; mc = 0; mn = 0; mrx = 0; pclk_old = 0;
      qp = '{0, 0}; qd = '{0, 0}; qr = '{1, 1}; qh = '{0, 0};
    end else begin
      req  = rst_disabled ? qh[1] : !qr[1];
      rise = qp[1] && !pclk_old;
      done = (ms == 2) && rise && qd[1] && (mc == N_ENTRY - 1);
      nxt = ms;
      if (ms == 0 && req) nxt = 1;
      else if (ms == 1) nxt = !req ? 0 : (delay_done ? 2 : 1);
      else if (ms == 2) nxt = !req ? 0 : (done ? 3 : 2);
      else if (ms == 3 && !req && !mn) nxt = 0;
      if (ms != 2 || done) mc = 0;
      else if (rise) mc = qd[1] ? mc + 1 : 0;
      if (ms == 3) begin
        if (nvm_clr) mn = 0;
        else if (nvm_set) mn = 1;
      end
      mrx = (nxt == 3) && (ms != 3);
      ms = nxt;
      pclk_old = qp[1];
      qp.push_front(pclk); void'(qp.pop_back());
      qd.push_front(pdata); void'(qd.pop_back());
      qr.push_front(rst_pin_n); void'(qr.pop_back());
      qh.push_front(hv_present); void'(qh.pop_back());
    end
  end

  always @(negedge clk) begin
    if (por_n && !finished) begin
      chk("R5 model phy_active", phy_active, ms == 3);
      chk("R3 model core_rst_req", core_rst_req, ms != 0);
      chk("R10 model phy_rx_init", phy_rx_init, mrx);
      chk("R11 model nvm_en", nvm_en, mn);
      if (phy_rx_init) rx_pulses++;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pcyc(bit d, int n);
    repeat (n) begin
      pclk = 1'b0; pdata = d;
      step(4);
      pclk = 1'b1;
      step(4);
    end
  endtask

  task automatic look();
    @(negedge clk);
  endtask

  task automatic pulse_nvm(bit s, bit c);
    nvm_set = s; nvm_clr = c;
    step(1);
    nvm_set = 1'b0; nvm_clr = 1'b0;
    step(4);
  endtask

  task automatic do_por();
    por_n = 1'b0;
    step(3);
    look();
    chk("R1 reset phy_active", phy_active, 0);
    chk("R1 reset nvm_en", nvm_en, 0);
    step(0);
    por_n = 1'b1;
    step(1);
  endtask

  initial begin
    step(3);
    look();
    chk("R1 reset core_rst_req", core_rst_req, 0);
    chk("R1 reset phy_rx_init", phy_rx_init, 0);
    step(0);
    por_n = 1'b1;
    look();
    chk("R1 first cycle phy_active", phy_active, 0);
    step(1);

    // unselected source ignored
    hv_present = 1'b1;
    step(6); look();
    chk("R2 hv ignored when pin selected", core_rst_req, 0);
    step(0);
    hv_present = 1'b0;

    // request, latency
    rst_pin_n = 1'b0;
    step(2); look();
    chk("R12 not yet after two edges", core_rst_req, 0);
    step(1); look();
    chk("R12 seen on third edge", core_rst_req, 1);
    step(0);
    pulse_nvm(1, 0);
    look();
    chk("R11 set ignored while inactive", nvm_en, 0);
    step(0);
    pcyc(1, 20);
    look();
    chk("R4 no entry before delay", phy_active, 0);
    step(0);

    // delay, count with restart
    delay_done = 1'b1;
    step(3);
    pcyc(1, 10);
    pcyc(0, 1);
    pcyc(1, 15);
    look();
    chk("R6 low sample restarted count", phy_active, 0);
    step(0);
    pcyc(1, 1);
    look();
    chk("R5 active after 16", phy_active, 1);
    chk("R10 one rx pulse", rx_pulses, 1);
    step(0);

    // locked session
    pulse_nvm(1, 0);
    look();
    chk("R11 set while active", nvm_en, 1);
    step(0);
    rst_pin_n = 1'b1;
    step(8); look();
    chk("R9 locked survives release", phy_active, 1);
    step(0);
    pulse_nvm(1, 1);
    look();
    chk("R11 clear wins", nvm_en, 0);
    chk("R8 released after clear", phy_active, 0);
    chk("R8 core reset released", core_rst_req, 0);
    step(0);

    // abort mid-count
    rst_pin_n = 1'b0;
    step(6);
    pcyc(1, 10);
    rst_pin_n = 1'b1;
    step(6); look();
    chk("R7 abort returns idle", core_rst_req, 0);
    step(0);
    rst_pin_n = 1'b0;
    step(6);
    pcyc(1, 6);
    look();
    chk("R7 count restarted on new request", phy_active, 0);
    step(0);
    pcyc(1, 10);
    look();
    chk("R5 active after fresh 16", phy_active, 1);
    step(0);
    pulse_nvm(1, 0);
    rst_pin_n = 1'b1;
    step(6);
    do_por();
    look();
    chk("R9 power-on clears locked", phy_active, 0);
    step(0);

    // high-voltage source
    rst_disabled = 1'b1;
    rst_pin_n = 1'b0;
    step(6); look();
    chk("R2 pin ignored when hv selected", core_rst_req, 0);
    step(0);
    hv_present = 1'b1;
    step(6);
    pcyc(1, 16);
    look();
    chk("R2 hv session entered", phy_active, 1);
    step(0);
    hv_present = 1'b0;
    step(4); look();
    chk("R8 hv removed exits", phy_active, 0);
    chk("R10 pulses total", rx_pulses, 3);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule